// File: doc/BRIEF.md
# Ring Buffer Wrap-Time Progress Checker

This block owns the write side of a circular buffer of fixed-size packet slots that several consumer threads drain in parallel. Slots are dealt out to consumers by static interleaving, so with N consumers, consumer c handles slots c, c+N, c+2N and so on. Every time a packet has been stored, the block steps its write slot index forward. It also flags, one-hot, which consumer owns the slot now being written.

Consumers report progress by sending the absolute index of the slot they are working on, through a per-consumer update strobe. The block keeps no per-slot valid or busy state. Its only overflow guard runs at the moment the write index moves from the last slot back to slot 0. At that moment the smallest reported progress among all consumers is compared with a precomputed threshold. If that minimum is not above the threshold, the traffic rate is declared unsustainable: a sticky failure flag is raised and the slowest consumer is reported.

The threshold is computed offline from the line rate, the worst-case per-packet processing time, the slot count and the minimum packet length. A slot that a neighbouring consumer reads as spill data is covered by the same check without any extra logic.

Top module: `wrap_checker`

## Requirements
- R1: After reset, writeIdx is 0, failFlag is 0, slowestId is 0 and ownerHot has only bit 0 set.
- R2: Each cycle with pktStored high moves writeIdx up by one. With pktStored low, writeIdx holds its value.
- R3: A pktStored pulse while writeIdx is NUM_SLOTS-1 returns writeIdx to 0 on the next cycle.
- R4: ownerHot is one-hot. Bit c is set exactly when writeIdx mod NUM_CONS equals c, so consumer c owns slots c, c+NUM_CONS, c+2*NUM_CONS and so on. This holds across wraps even when NUM_SLOTS is not a multiple of NUM_CONS.
- R5: A high progValid[c] stores the field progIdx[c*IDXW +: IDXW] as the progress of consumer c. A value of NUM_SLOTS or more is ignored, and the previous progress is kept.
- R6: The progress check runs only on a wrapping pktStored pulse. If the minimum stored progress is less than or equal to cfgThreshold, failFlag is 1 on the next cycle. If the minimum is greater than cfgThreshold, the wrap leaves failFlag unchanged. Low progress between wraps never sets failFlag.
- R7: The wrap check uses the progress values stored before the wrap cycle. A progress update in that same cycle counts only from the next check onward.
- R8: failFlag stays set until failClr is high. If a failing wrap and failClr fall in the same cycle, the flag stays set.
- R9: At each failing wrap, slowestId takes the index of the consumer with the smallest progress. On a tie, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStored | input | 1 | One pulse per packet fully written to the current slot |
| progValid | input | NUM_CONS | Per-consumer progress update strobe |
| progIdx | input | NUM_CONS*IDXW | Per-consumer progress slot index; field c is bits c*IDXW +: IDXW |
| cfgThreshold | input | IDXW | Precomputed minimum acceptable progress at wrap time |
| failClr | input | 1 | Clears the sticky failure flag |
| writeIdx | output | IDXW | Slot index being written next |
| ownerHot | output | NUM_CONS | One-hot owner of the slot at writeIdx |
| failFlag | output | 1 | Sticky rate-overflow failure |
| slowestId | output | CIDW | Slowest consumer at the latest failing wrap |

## Verification
The hardest case to reach is a failing wrap whose outcome hinges on one detail: a progress value exactly at the threshold, a tie between two lagging consumers, an out-of-range update that has to be dropped, or an update that lands in the wrap cycle itself. Each of these is only visible at the single clock edge where the index wraps. The stimulus walks the write index packet by packet to the last slot, fixes every consumer's progress beforehand, and then issues the wrapping pulse alone or together with the conflicting input. The bench runs with a slot count that is not a multiple of the consumer count, so that the owner realignment at wrap is exercised.

// File: rtl/wrap_checker_pkg.sv
package wrap_checker_pkg;

  // Strobes from control to datapath, one cycle each.
  typedef struct packed {
    logic advance;   // a packet was stored: step the write index
    logic wrap;      // the step goes from the last slot to slot 0
    logic setFail;   // wrap check failed: latch the slowest consumer
    logic clrFail;   // failure flag being cleared
  } ctrlStrobes_t;

endpackage

// File: rtl/wrap_checker_datapath.sv
module wrap_checker_datapath
  import wrap_checker_pkg::*;
#(
  parameter int NUM_CONS  = 10,
  parameter int NUM_SLOTS = 100,
  parameter int IDXW      = $clog2(NUM_SLOTS),
  parameter int CIDW      = (NUM_CONS > 1) ? $clog2(NUM_CONS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic [NUM_CONS-1:0]      progValid,
  input  logic [NUM_CONS*IDXW-1:0] progIdx,
  input  logic [IDXW-1:0]          cfgThreshold,
  output logic                     atLast,
  output logic                     lagging,
  output logic [IDXW-1:0]          writeIdx,
  output logic [NUM_CONS-1:0]      ownerHot,
  output logic [CIDW-1:0]          slowestId
);

  localparam logic [IDXW-1:0] LAST_SLOT = IDXW'(NUM_SLOTS - 1);
  localparam logic [CIDW-1:0] LAST_CONS = CIDW'(NUM_CONS - 1);

  logic [IDXW-1:0] progReg [NUM_CONS];
  logic [CIDW-1:0] ownerCnt;
  logic [IDXW-1:0] minVal;
  logic [CIDW-1:0] minId;

  // Write slot index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      writeIdx <= '0;
    end else if (strobes.wrap) begin
      writeIdx <= '0;
    end else if (strobes.advance) begin
      writeIdx <= writeIdx + 1'b1;
    end
  end

  assign atLast = (writeIdx == LAST_SLOT);

  // Owner counter tracks writeIdx mod NUM_CONS without a divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerCnt <= '0;
    end else if (strobes.wrap) begin
      ownerCnt <= '0;
    end else if (strobes.advance) begin
      ownerCnt <= (ownerCnt == LAST_CONS) ? '0 : ownerCnt + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CONS; g++) begin : gOwner
    assign ownerHot[g] = (ownerCnt == CIDW'(g));
  end

  // Per-consumer progress registers; out-of-range reports dropped
  for (genvar g = 0; g < NUM_CONS; g++) begin : gProg
    logic [IDXW-1:0] newVal;
    assign newVal = progIdx[g*IDXW +: IDXW];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        progReg[g] <= '0;
      end else if (progValid[g] && (int'(newVal) < NUM_SLOTS)) begin
        progReg[g] <= newVal;
      end
    end
  end

  // Slowest consumer, ties to the lowest index
  always_comb begin
    minVal = progReg[0];
    minId  = '0;
    for (int c = 1; c < NUM_CONS; c++) begin
      if (progReg[c] < minVal) begin
        minVal = progReg[c];
        minId  = CIDW'(c);
      end
    end
  end

  assign lagging = (minVal <= cfgThreshold);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slowestId <= '0;
    end else if (strobes.setFail) begin
      slowestId <= minId;
    end
  end

  // R1 / R3: index never leaves the buffer
  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(writeIdx) < NUM_SLOTS);

  // R2: step by one on a non-wrapping packet
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !atLast) |=> (writeIdx == $past(writeIdx) + 1'b1));

  // R2: hold without a packet
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(writeIdx));

  // R3: return to slot 0
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> (writeIdx == '0));

  // R4: exactly one owner, realigned to consumer 0 at slot 0
  a_r4_owner_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(ownerHot));

  a_r4_owner_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (writeIdx == '0) |-> ownerHot[0]);

endmodule

// File: rtl/wrap_checker_control.sv
module wrap_checker_control
  import wrap_checker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pktStored,
  input  logic         failClr,
  input  logic         atLast,
  input  logic         lagging,
  output ctrlStrobes_t strobes,
  output logic         failFlag
);

  always_comb begin
    strobes.advance = pktStored;
    strobes.wrap    = pktStored && atLast;
    strobes.setFail = strobes.wrap && lagging;
    strobes.clrFail = failClr && !strobes.setFail;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag <= 1'b0;
    end else if (strobes.setFail) begin
      failFlag <= 1'b1;
    end else if (strobes.clrFail) begin
      failFlag <= 1'b0;
    end
  end

  // R6: failure only appears right after a wrapping packet
  a_r6_only_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (!failFlag && !(pktStored && atLast)) |=> !failFlag);

  // R8: sticky without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !failClr) |=> failFlag);

  // R8: a failing wrap beats a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (pktStored && atLast && lagging) |=> failFlag);

endmodule

// File: rtl/wrap_checker.sv
module wrap_checker
  import wrap_checker_pkg::*;
#(
  parameter int NUM_CONS  = 10,
  parameter int NUM_SLOTS = 100,
  parameter int IDXW      = $clog2(NUM_SLOTS),
  parameter int CIDW      = (NUM_CONS > 1) ? $clog2(NUM_CONS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     pktStored,
  input  logic [NUM_CONS-1:0]      progValid,
  input  logic [NUM_CONS*IDXW-1:0] progIdx,
  input  logic [IDXW-1:0]          cfgThreshold,
  input  logic                     failClr,
  output logic [IDXW-1:0]          writeIdx,
  output logic [NUM_CONS-1:0]      ownerHot,
  output logic                     failFlag,
  output logic [CIDW-1:0]          slowestId
);

  ctrlStrobes_t strobes;
  logic atLast;
  logic lagging;

  wrap_checker_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pktStored(pktStored),
    .failClr  (failClr),
    .atLast   (atLast),
    .lagging  (lagging),
    .strobes  (strobes),
    .failFlag (failFlag)
  );

  wrap_checker_datapath #(
    .NUM_CONS (NUM_CONS),
    .NUM_SLOTS(NUM_SLOTS),
    .IDXW     (IDXW),
    .CIDW     (CIDW)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .progValid   (progValid),
    .progIdx     (progIdx),
    .cfgThreshold(cfgThreshold),
    .atLast      (atLast),
    .lagging     (lagging),
    .writeIdx    (writeIdx),
    .ownerHot    (ownerHot),
    .slowestId   (slowestId)
  );

endmodule

// File: tb/tb_wrap_checker.sv
`timescale 1ns/1ps
module tb_wrap_checker;

  localparam int NC   = 4;
  localparam int NS   = 22;
  localparam int W    = $clog2(NS);
  localparam int CW   = $clog2(NC);
  localparam int THR  = 10;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           pktStored = 1'b0;
  logic [NC-1:0]  progValid = '0;
  logic [NC*W-1:0] progIdx = '0;
  logic [W-1:0]   cfgThreshold = W'(THR);
  logic           failClr = 1'b0;
  logic [W-1:0]   writeIdx;
  logic [NC-1:0]  ownerHot;
  logic           failFlag;
  logic [CW-1:0]  slowestId;

  int checks = 0;
  int fails  = 0;
  int expIdx = 0;

  always #2 clk = ~clk;

  wrap_checker #(.NUM_CONS(NC), .NUM_SLOTS(NS)) dut (
    .clk(clk), .rstN(rstN), .pktStored(pktStored), .progValid(progValid),
    .progIdx(progIdx), .cfgThreshold(cfgThreshold), .failClr(failClr),
    .writeIdx(writeIdx), .ownerHot(ownerHot), .failFlag(failFlag),
    .slowestId(slowestId)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pkt();
    @(negedge clk) pktStored = 1'b1;
    @(negedge clk) pktStored = 1'b0;
    expIdx = (expIdx == NS - 1) ? 0 : expIdx + 1;
  endtask

  task automatic advanceTo(int target);
    while (expIdx != target) pkt();
  endtask

  task automatic setProg(int c, int v);
    @(negedge clk);
    progIdx[c*W +: W] = W'(v);
    progValid = NC'(1) << c;
    @(negedge clk) progValid = '0;
  endtask

  task automatic setAll(int v0, int v1, int v2, int v3);
    setProg(0, v0); setProg(1, v1); setProg(2, v2); setProg(3, v3);
  endtask

  task automatic clearFail();
    @(negedge clk) failClr = 1'b1;
    @(negedge clk) failClr = 1'b0;
  endtask

  task automatic wrapNow();
    advanceTo(NS - 1);
    pkt();
  endtask

  task automatic tReset();
    chk("R1 writeIdx", int'(writeIdx), 0);
    chk("R1 failFlag", int'(failFlag), 0);
    chk("R1 slowestId", int'(slowestId), 0);
    chk("R1 ownerHot", int'(ownerHot), 1);
  endtask

  task automatic tAdvance();
    advanceTo(5);
    chk("R2 writeIdx after 5", int'(writeIdx), 5);
    chk("R4 ownerHot slot 5", int'(ownerHot), 2);
    repeat (3) @(negedge clk);
    chk("R2 hold without pkt", int'(writeIdx), 5);
    advanceTo(NS - 1);
    chk("R4 ownerHot last slot", int'(ownerHot), 1 << ((NS - 1) % NC));
  endtask

  task automatic tWrapPass();
    setAll(15, 16, 17, 18);
    wrapNow();
    chk("R3 writeIdx after wrap", int'(writeIdx), 0);
    chk("R4 ownerHot realigned", int'(ownerHot), 1);
    chk("R6 pass keeps flag low", int'(failFlag), 0);
  endtask

  task automatic tMidLowNoFail();
    setAll(15, 16, 3, 18);
    advanceTo(NS - 1);
    chk("R6 no check before wrap", int'(failFlag), 0);
  endtask

  task automatic tWrapFail();
    pkt();
    chk("R6 lag sets failFlag", int'(failFlag), 1);
    chk("R9 slowest is 2", int'(slowestId), 2);
  endtask

  task automatic tSticky();
    setAll(15, 16, 17, 18);
    advanceTo(7);
    chk("R8 sticky mid buffer", int'(failFlag), 1);
    wrapNow();
    chk("R8 sticky after passing wrap", int'(failFlag), 1);
    clearFail();
    chk("R8 clear", int'(failFlag), 0);
  endtask

  task automatic tBoundary();
    setAll(THR, 16, 17, 18);
    wrapNow();
    chk("R6 min equal threshold fails", int'(failFlag), 1);
    chk("R9 slowest is 0", int'(slowestId), 0);
    clearFail();
    setProg(0, THR + 1);
    wrapNow();
    chk("R6 min threshold+1 passes", int'(failFlag), 0);
  endtask

  task automatic tTie();
    setAll(15, 5, 17, 5);
    wrapNow();
    chk("R9 tie flag", int'(failFlag), 1);
    chk("R9 tie lowest index", int'(slowestId), 1);
    clearFail();
  endtask

  task automatic tOutOfRange();
    setAll(15, 16, 17, 4);
    setProg(3, NS + 3);
    wrapNow();
    chk("R5 out-of-range ignored flag", int'(failFlag), 1);
    chk("R5 out-of-range ignored slowest", int'(slowestId), 3);
    clearFail();
    setProg(3, 20);
    wrapNow();
    chk("R5 in-range update taken", int'(failFlag), 0);
  endtask

  task automatic tSameCycleUpdate();
    setAll(2, 16, 17, 18);
    advanceTo(NS - 1);
    @(negedge clk);
    pktStored = 1'b1;
    progIdx[0 +: W] = W'(20);
    progValid = 4'b0001;
    @(negedge clk);
    pktStored = 1'b0;
    progValid = '0;
    expIdx = 0;
    chk("R7 old progress used", int'(failFlag), 1);
    chk("R7 slowest is 0", int'(slowestId), 0);
    clearFail();
    wrapNow();
    chk("R7 new progress used next wrap", int'(failFlag), 0);
  endtask

  task automatic tSetBeatsClear();
    setAll(15, 16, 1, 18);
    advanceTo(NS - 1);
    @(negedge clk);
    pktStored = 1'b1;
    failClr = 1'b1;
    @(negedge clk);
    pktStored = 1'b0;
    failClr = 1'b0;
    expIdx = 0;
    chk("R8 set beats clear", int'(failFlag), 1);
    chk("R9 slowest is 2 again", int'(slowestId), 2);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAdvance();
    tWrapPass();
    tMidLowNoFail();
    tWrapFail();
    tSticky();
    tBoundary();
    tTie();
    tOutOfRange();
    tSameCycleUpdate();
    tSetBeatsClear();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule